// File: doc/BRIEF.md
# Reorder Queue Statistics Counter Bank

This block keeps the event statistics of one receive reorder queue. The reorder and duplicate-detection logic around it raise one-cycle strobes when something happens: a forced forward on timeout, a forced forward caused by a block-ack request, a block-ack request arriving, a late frame, a 2K sequence-window jump, a duplicate, a hole, an in-order delivery or an aging drop. Each strobe bumps its own counter. Some counters are narrow and hold at their maximum. The rest wrap to zero when they overflow.

Every processed frame arrives on a valid/ready input that carries its MSDU count and its length in bytes. An accepted frame adds one to the MPDU total and its MSDU count to the MSDU total. It also adds its length to a byte total, which is kept in 64-byte units. Duplicates and frames that later fail are counted like any other frame. The ready output is low only during a software clear, so the upstream logic holds a frame for that single cycle and offers it again in the next one. A software clear sets every counter to zero in one cycle, and it wins over any event in the same cycle. All counter values are presented in parallel.

Top module: `rqs_bank`

## Requirements
- R1: After reset, and in the cycle after a software clear, every counter output is zero.
- R2: When `sw_clr` is high, `frm_ready` is low. Events and frames presented in that cycle are not counted, and all counters read zero after it.
- R3: `cnt_tmo_fwd` and `cnt_req_fwd` are 6 bits wide and count their strobes. They stay at 63 once they reach it.
- R4: `cnt_req_rx` is 8 bits wide and counts block-ack requests received. It stays at 255 once it reaches it.
- R5: `cnt_late` is 12 bits wide and counts late frames. It stays at 4095 once it reaches it.
- R6: `cnt_jump` is 4 bits wide and counts 2K window jumps. It stays at 15 once it reaches it.
- R7: `cnt_dup`, `cnt_hole` and `cnt_age_drop` are 16 bits wide and count their strobes. Each goes from 65535 to 0 on the next strobe.
- R8: `cnt_inorder` is 24 bits wide, counts in-order strobes, and wraps to zero on overflow.
- R9: A frame is accepted when `frm_valid` and `frm_ready` are both high. Each accepted frame adds 1 to `cnt_mpdu` and adds `frm_msdus` to `cnt_msdu`. Both counters are 32 bits and wrap. A duplicate strobe in the same cycle does not stop the frame from being counted.
- R10: Each accepted frame adds ceil(`frm_len`/64) to `cnt_blk64`, which is 32 bits and wraps. A length of 0 adds 0, lengths 1 to 64 add 1, and a length of 65 adds 2.
- R11: A strobe or an accepted frame in one cycle shows on the counter outputs after the next rising clock edge and not before. With no strobe and no clear, a counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_clr | input | 1 | Software clear of all counters |
| ev_tmo_fwd | input | 1 | Forward forced by timeout |
| ev_req_fwd | input | 1 | Forward forced by a block-ack request |
| ev_req_rx | input | 1 | Block-ack request received |
| ev_late | input | 1 | Late frame |
| ev_jump | input | 1 | 2K window jump |
| ev_dup | input | 1 | Duplicate detected |
| ev_hole | input | 1 | Hole in the window |
| ev_inorder | input | 1 | Frame delivered in order |
| ev_age_drop | input | 1 | Frame dropped by aging |
| frm_valid | input | 1 | Processed frame offered |
| frm_ready | output | 1 | Frame accepted this cycle when valid |
| frm_msdus | input | 8 | MSDUs in the offered frame |
| frm_len | input | 16 | Byte length of the offered frame |
| cnt_tmo_fwd | output | 6 | Timeout forward count |
| cnt_req_fwd | output | 6 | Request-forced forward count |
| cnt_req_rx | output | 8 | Block-ack requests received |
| cnt_late | output | 12 | Late frame count |
| cnt_jump | output | 4 | 2K window jump count |
| cnt_dup | output | 16 | Duplicate count |
| cnt_hole | output | 16 | Hole count |
| cnt_inorder | output | 24 | In-order frame count |
| cnt_age_drop | output | 16 | Aging drop count |
| cnt_mpdu | output | 32 | Processed MPDU count |
| cnt_msdu | output | 32 | Processed MSDU count |
| cnt_blk64 | output | 32 | Processed bytes in 64-byte units |

## Verification
Long runs of back-to-back strobes push every narrow counter past its maximum. This tells a counter that holds at its limit from one that wraps or carries into a neighbour, and the 16-bit counters are driven through 65535 to show that they do wrap. Frame lengths of 0, 1, 63, 64, 65 and 65535 tell a correct round-up apart from a truncating divide or an off-by-one. A clear asserted together with every strobe and a valid frame shows that the clear wins and that the frame is held off. Random mixes of strobes, frames and occasional clears then show that the counters do not interfere with each other.

// File: rtl/rqs_pkg.sv
package rqs_pkg;
  // Counter widths
  localparam int TMO_W    = 6;
  localparam int REQF_W   = 6;
  localparam int REQRX_W  = 8;
  localparam int LATE_W   = 12;
  localparam int JUMP_W   = 4;
  localparam int DUP_W    = 16;
  localparam int HOLE_W   = 16;
  localparam int INORD_W  = 24;
  localparam int AGE_W    = 16;
  localparam int TOT_W    = 32;
  // Frame input widths
  localparam int MSDU_W   = 8;
  localparam int LEN_W    = 16;
  // Byte unit is 2**UNIT_SH bytes
  localparam int UNIT_SH  = 6;
  localparam int BLK_W    = LEN_W - UNIT_SH + 1;

  typedef enum logic [3:0] {
    EV_TMO_FWD, EV_REQ_FWD, EV_REQ_RX, EV_LATE, EV_JUMP,
    EV_DUP, EV_HOLE, EV_INORDER, EV_AGE_DROP
  } ev_idx_e;
  localparam int NUM_EV = 9;
endpackage

// File: rtl/rqs_ctr.sv
module rqs_ctr #(
  parameter int W     = 8,
  parameter int INC_W = 1,
  parameter bit SAT   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc_en,
  input  logic [INC_W-1:0] inc_amt,
  output logic [W-1:0]     cnt
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] nxt;

  generate
    if (SAT) begin : g_sat
      logic [W:0] sum_ext;
      assign sum_ext = {1'b0, cnt} + {{(W+1-INC_W){1'b0}}, inc_amt};
      assign nxt = sum_ext[W] ? MAXV : sum_ext[W-1:0];

      AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !clr) |=> (cnt == MAXV)); // R3
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> (cnt >= $past(cnt))); // R3
    end else begin : g_wrap
      assign nxt = cnt + {{(W-INC_W){1'b0}}, inc_amt};

      AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !clr && inc_en && inc_amt == INC_W'(1)) |=> (cnt == '0)); // R7
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (inc_en) cnt <= nxt;
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R1
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc_en) |=> $stable(cnt)); // R11
endmodule

// File: rtl/rqs_blk_round.sv
module rqs_blk_round #(
  parameter int LEN_W = 16,
  parameter int SH    = 6,
  localparam int OUT_W = LEN_W - SH + 1
) (
  input  logic [LEN_W-1:0] len,
  output logic [OUT_W-1:0] blks
);
  logic [OUT_W-1:0] whole;
  logic             part;

  assign whole = {1'b0, len[LEN_W-1:SH]};
  assign part  = |len[SH-1:0];
  assign blks  = whole + {{(OUT_W-1){1'b0}}, part};

  always_comb begin
    AST_ROUND_UP: assert (({blks, {SH{1'b0}}} >= {{SH{1'b0}}, 1'b0, len})); // R10
  end
endmodule

// File: rtl/rqs_bank.sv
module rqs_bank
  import rqs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_clr,
  input  logic                ev_tmo_fwd,
  input  logic                ev_req_fwd,
  input  logic                ev_req_rx,
  input  logic                ev_late,
  input  logic                ev_jump,
  input  logic                ev_dup,
  input  logic                ev_hole,
  input  logic                ev_inorder,
  input  logic                ev_age_drop,
  input  logic                frm_valid,
  output logic                frm_ready,
  input  logic [MSDU_W-1:0]   frm_msdus,
  input  logic [LEN_W-1:0]    frm_len,
  output logic [TMO_W-1:0]    cnt_tmo_fwd,
  output logic [REQF_W-1:0]   cnt_req_fwd,
  output logic [REQRX_W-1:0]  cnt_req_rx,
  output logic [LATE_W-1:0]   cnt_late,
  output logic [JUMP_W-1:0]   cnt_jump,
  output logic [DUP_W-1:0]    cnt_dup,
  output logic [HOLE_W-1:0]   cnt_hole,
  output logic [INORD_W-1:0]  cnt_inorder,
  output logic [AGE_W-1:0]    cnt_age_drop,
  output logic [TOT_W-1:0]    cnt_mpdu,
  output logic [TOT_W-1:0]    cnt_msdu,
  output logic [TOT_W-1:0]    cnt_blk64
);
  logic [NUM_EV-1:0] ev;
  logic              frm_acc;
  logic [BLK_W-1:0]  frm_blks;

  assign ev[EV_TMO_FWD]  = ev_tmo_fwd;
  assign ev[EV_REQ_FWD]  = ev_req_fwd;
  assign ev[EV_REQ_RX]   = ev_req_rx;
  assign ev[EV_LATE]     = ev_late;
  assign ev[EV_JUMP]     = ev_jump;
  assign ev[EV_DUP]      = ev_dup;
  assign ev[EV_HOLE]     = ev_hole;
  assign ev[EV_INORDER]  = ev_inorder;
  assign ev[EV_AGE_DROP] = ev_age_drop;

  // A clear cycle refuses the frame; upstream re-offers it next cycle
  assign frm_ready = ~sw_clr;
  assign frm_acc   = frm_valid & frm_ready;

  // Saturating event counters
  rqs_ctr #(.W(TMO_W), .INC_W(1), .SAT(1'b1)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr), .inc_en(ev[EV_TMO_FWD]),
    .inc_amt(1'b1), .cnt(cnt_tmo_fwd));
  rqs_ctr #(.W(REQF_W), .INC_W(1), .SAT(1'b1)) u_reqf (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr), .inc_en(ev[EV_REQ_FWD]),
    .inc_amt(1'b1), .cnt(cnt_req_fwd));
  rqs_ctr #(.W(REQRX_W), .INC_W(1), .SAT(1'b1)) u_reqrx (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr), .inc_en(ev[EV_REQ_RX]),
    .inc_amt(1'b1), .cnt(cnt_req_rx));
  rqs_ctr #(.W(LATE_W), .INC_W(1), .SAT(1'b1)) u_late (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr), .inc_en(ev[EV_LATE]),
    .inc_amt(1'b1), .cnt(cnt_late));
  rqs_ctr #(.W(JUMP_W), .INC_W(1), .SAT(1'b1)) u_jump (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr), .inc_en(ev[EV_JUMP]),
    .inc_amt(1'b1), .cnt(cnt_jump));

  // Wrapping event counters
  rqs_ctr #(.W(DUP_W), .INC_W(1), .SAT(1'b0)) u_dup (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr), .inc_en(ev[EV_DUP]),
    .inc_amt(1'b1), .cnt(cnt_dup));
  rqs_ctr #(.W(HOLE_W), .INC_W(1), .SAT(1'b0)) u_hole (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr), .inc_en(ev[EV_HOLE]),
    .inc_amt(1'b1), .cnt(cnt_hole));
  rqs_ctr #(.W(INORD_W), .INC_W(1), .SAT(1'b0)) u_inord (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr), .inc_en(ev[EV_INORDER]),
    .inc_amt(1'b1), .cnt(cnt_inorder));
  rqs_ctr #(.W(AGE_W), .INC_W(1), .SAT(1'b0)) u_age (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr), .inc_en(ev[EV_AGE_DROP]),
    .inc_amt(1'b1), .cnt(cnt_age_drop));

  // Processed-frame totals
  rqs_blk_round #(.LEN_W(LEN_W), .SH(UNIT_SH)) u_round (
    .len(frm_len), .blks(frm_blks));

  rqs_ctr #(.W(TOT_W), .INC_W(1), .SAT(1'b0)) u_mpdu (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr), .inc_en(frm_acc),
    .inc_amt(1'b1), .cnt(cnt_mpdu));
  rqs_ctr #(.W(TOT_W), .INC_W(MSDU_W), .SAT(1'b0)) u_msdu (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr), .inc_en(frm_acc),
    .inc_amt(frm_msdus), .cnt(cnt_msdu));
  rqs_ctr #(.W(TOT_W), .INC_W(BLK_W), .SAT(1'b0)) u_blk (
    .clk(clk), .rst_n(rst_n), .clr(sw_clr), .inc_en(frm_acc),
    .inc_amt(frm_blks), .cnt(cnt_blk64));

  AST_CLR_BLOCKS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> (cnt_mpdu == '0 && cnt_blk64 == '0 && cnt_dup == '0)); // R2
  AST_MPDU_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |=> (cnt_mpdu == $past(cnt_mpdu) + 32'd1)); // R9
  AST_BLK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && frm_len != '0) |=> (cnt_blk64 != $past(cnt_blk64))); // R10
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_jump == 4'hF && !sw_clr) |=> (cnt_jump == 4'hF)); // R6
endmodule

// File: tb/rqs_bank_tb.sv
module rqs_bank_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_clr = 1'b0;
  logic ev_tmo_fwd = 0, ev_req_fwd = 0, ev_req_rx = 0, ev_late = 0, ev_jump = 0;
  logic ev_dup = 0, ev_hole = 0, ev_inorder = 0, ev_age_drop = 0;
  logic frm_valid = 0;
  logic frm_ready;
  logic [7:0]  frm_msdus = '0;
  logic [15:0] frm_len = '0;
  logic [5:0]  cnt_tmo_fwd, cnt_req_fwd;
  logic [7:0]  cnt_req_rx;
  logic [11:0] cnt_late;
  logic [3:0]  cnt_jump;
  logic [15:0] cnt_dup, cnt_hole, cnt_age_drop;
  logic [23:0] cnt_inorder;
  logic [31:0] cnt_mpdu, cnt_msdu, cnt_blk64;

  always #(CLK_P/2) clk = ~clk;

  rqs_bank u_dut (
    .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr),
    .ev_tmo_fwd(ev_tmo_fwd), .ev_req_fwd(ev_req_fwd), .ev_req_rx(ev_req_rx),
    .ev_late(ev_late), .ev_jump(ev_jump), .ev_dup(ev_dup), .ev_hole(ev_hole),
    .ev_inorder(ev_inorder), .ev_age_drop(ev_age_drop),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_msdus(frm_msdus), .frm_len(frm_len),
    .cnt_tmo_fwd(cnt_tmo_fwd), .cnt_req_fwd(cnt_req_fwd), .cnt_req_rx(cnt_req_rx),
    .cnt_late(cnt_late), .cnt_jump(cnt_jump), .cnt_dup(cnt_dup), .cnt_hole(cnt_hole),
    .cnt_inorder(cnt_inorder), .cnt_age_drop(cnt_age_drop),
    .cnt_mpdu(cnt_mpdu), .cnt_msdu(cnt_msdu), .cnt_blk64(cnt_blk64));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Expected values, kept independently of the design
  longint m_tmo, m_reqf, m_reqrx, m_late, m_jump, m_dup, m_hole, m_inord, m_age;
  longint m_mpdu, m_msdu, m_blk;

  function automatic longint sat_inc(longint v, longint maxv, logic en);
    if (!en) return v;
    return (v >= maxv) ? maxv : v + 1;
  endfunction

  function automatic longint wrap_add(longint v, longint amt, int w);
    return (v + amt) % (longint'(1) << w);
  endfunction

  function automatic longint units64(longint len);
    return len / 64 + ((len % 64) != 0 ? 1 : 0);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_zero();
    m_tmo = 0; m_reqf = 0; m_reqrx = 0; m_late = 0; m_jump = 0;
    m_dup = 0; m_hole = 0; m_inord = 0; m_age = 0;
    m_mpdu = 0; m_msdu = 0; m_blk = 0;
  endtask

  task automatic check_all(string ctx);
    chk("R3", {ctx, " tmo_fwd"}, cnt_tmo_fwd, m_tmo);
    chk("R3", {ctx, " req_fwd"}, cnt_req_fwd, m_reqf);
    chk("R4", {ctx, " req_rx"},  cnt_req_rx,  m_reqrx);
    chk("R5", {ctx, " late"},    cnt_late,    m_late);
    chk("R6", {ctx, " jump"},    cnt_jump,    m_jump);
    chk("R7", {ctx, " dup"},     cnt_dup,     m_dup);
    chk("R7", {ctx, " hole"},    cnt_hole,    m_hole);
    chk("R7", {ctx, " age"},     cnt_age_drop, m_age);
    chk("R8", {ctx, " inorder"}, cnt_inorder, m_inord);
    chk("R9", {ctx, " mpdu"},    cnt_mpdu,    m_mpdu);
    chk("R9", {ctx, " msdu"},    cnt_msdu,    m_msdu);
    chk("R10", {ctx, " blk64"},  cnt_blk64,   m_blk);
  endtask

  // Update model for the current inputs, then advance one clock
  task automatic tick();
    if (sw_clr) model_zero();
    else begin
      m_tmo   = sat_inc(m_tmo, 63, ev_tmo_fwd);
      m_reqf  = sat_inc(m_reqf, 63, ev_req_fwd);
      m_reqrx = sat_inc(m_reqrx, 255, ev_req_rx);
      m_late  = sat_inc(m_late, 4095, ev_late);
      m_jump  = sat_inc(m_jump, 15, ev_jump);
      m_dup   = wrap_add(m_dup, ev_dup, 16);
      m_hole  = wrap_add(m_hole, ev_hole, 16);
      m_age   = wrap_add(m_age, ev_age_drop, 16);
      m_inord = wrap_add(m_inord, ev_inorder, 24);
      if (frm_valid) begin
        m_mpdu = wrap_add(m_mpdu, 1, 32);
        m_msdu = wrap_add(m_msdu, frm_msdus, 32);
        m_blk  = wrap_add(m_blk, units64(frm_len), 32);
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    sw_clr = 0; ev_tmo_fwd = 0; ev_req_fwd = 0; ev_req_rx = 0; ev_late = 0;
    ev_jump = 0; ev_dup = 0; ev_hole = 0; ev_inorder = 0; ev_age_drop = 0;
    frm_valid = 0; frm_msdus = '0; frm_len = '0;
  endtask

  task automatic one_frame(int len, int msdus);
    frm_valid = 1; frm_len = 16'(len); frm_msdus = 8'(msdus);
    tick();
    idle_inputs();
    chk("R10", $sformatf("blk64 after len %0d", len), cnt_blk64, m_blk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_zero();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");
    chk("R2", "ready idle", frm_ready, 1);

    // R11: no change before the edge, change after
    ev_tmo_fwd = 1;
    #1;
    chk("R11", "tmo before edge", cnt_tmo_fwd, 0);
    tick();
    idle_inputs();
    chk("R11", "tmo after edge", cnt_tmo_fwd, 1);
    tick();
    chk("R11", "tmo held idle", cnt_tmo_fwd, 1);

    // R3 R4 R5 R6 saturation
    ev_tmo_fwd = 1; ev_req_fwd = 1; ev_req_rx = 1; ev_late = 1; ev_jump = 1;
    repeat (4100) tick();
    idle_inputs();
    check_all("saturate");
    chk("R5", "late at max", cnt_late, 4095);
    chk("R6", "jump at max", cnt_jump, 15);

    // R7 wrap through 65535
    ev_dup = 1; ev_hole = 1; ev_age_drop = 1; ev_inorder = 1;
    repeat (65538) tick();
    idle_inputs();
    check_all("wrap");
    chk("R7", "dup wrapped", cnt_dup, 2);

    // R2 clear priority over every input
    sw_clr = 1; ev_tmo_fwd = 1; ev_req_fwd = 1; ev_req_rx = 1; ev_late = 1; ev_jump = 1;
    ev_dup = 1; ev_hole = 1; ev_inorder = 1; ev_age_drop = 1;
    frm_valid = 1; frm_len = 16'd1000; frm_msdus = 8'd5;
    #1;
    chk("R2", "ready during clear", frm_ready, 0);
    tick();
    idle_inputs();
    check_all("R2 clear");
    chk("R1", "mpdu after clear", cnt_mpdu, 0);

    // R10 length corner cases
    one_frame(0, 1);
    one_frame(1, 1);
    one_frame(63, 2);
    one_frame(64, 3);
    one_frame(65, 4);
    one_frame(65535, 255);
    chk("R10", "blk64 total", cnt_blk64, 0 + 1 + 1 + 1 + 2 + 1024);
    chk("R9", "msdu total", cnt_msdu, 266);

    // R9 duplicate in same cycle still counted
    ev_dup = 1; frm_valid = 1; frm_len = 16'd10; frm_msdus = 8'd1;
    tick();
    idle_inputs();
    chk("R9", "dup frame counted", cnt_mpdu, m_mpdu);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      sw_clr      = ($urandom_range(0, 199) == 0);
      ev_tmo_fwd  = $urandom_range(0, 2) == 0;
      ev_req_fwd  = $urandom_range(0, 2) == 0;
      ev_req_rx   = $urandom_range(0, 1) == 0;
      ev_late     = $urandom_range(0, 1) == 0;
      ev_jump     = $urandom_range(0, 3) == 0;
      ev_dup      = $urandom_range(0, 1) == 0;
      ev_hole     = $urandom_range(0, 1) == 0;
      ev_inorder  = $urandom_range(0, 1) == 0;
      ev_age_drop = $urandom_range(0, 2) == 0;
      frm_valid   = $urandom_range(0, 1) == 0;
      frm_msdus   = 8'($urandom_range(0, 255));
      case ($urandom_range(0, 5))
        0: frm_len = 16'd0;
        1: frm_len = 16'd64;
        2: frm_len = 16'd65;
        default: frm_len = 16'($urandom_range(0, 65535));
      endcase
      tick();
      check_all("random");
    end
    idle_inputs();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule